// File: doc/BRIEF.md
# Carry-Skip Block Adder

A purely combinational binary adder that takes two operands and an incoming carry. It returns their sum and the outgoing carry. The operand width is cut into equal groups of bits. Within each group the carry ripples from bit to bit. Each group also forms a single bypass flag, which is true when every bit of the group would pass a carry through unchanged. When that flag is set, the carry that enters the group is steered straight to the group's carry output, so it does not wait for the ripple.

The slowest path therefore starts with a carry generated at the lowest bit. It ripples to the top of the first group, jumps over the middle groups through their bypass multiplexers, and ripples once more through the last group. An optional second bypass level pairs neighbouring groups so that a carry can jump over two of them at once. It changes only the timing shape and never the result. The block fits where a datapath needs a mid-speed adder that costs little more area than a plain ripple chain.

Top module: `skip_adder`

## Requirements
- R1: `sum_out` equals the low WIDTH bits of `a_in + b_in + c_in`, for every operand pair and both carry-in values.
- R2: `c_out` equals bit WIDTH of `a_in + b_in + c_in`.
- R3: With `b_in` the bitwise complement of `a_in`, every bit propagates. With `c_in`=0 the result is all ones and `c_out`=0. With `c_in`=1 the result is all zeros and `c_out`=1.
- R4: A carry made at bit 0 (`a_in`=1, `b_in`=all ones, `c_in`=0) reaches the top and gives `sum_out`=0 and `c_out`=1.
- R5: When every bit of a group has `a_in` XOR `b_in` = 1, the group's carry output equals the group's carry input.
- R6: When at least one bit of a group does not propagate, the group's carry output is the carry rippled through that group's bits.
- R7: A bit with both operand bits set generates a carry and is not treated as propagating. For example, `a_in`=`b_in`=0x000F with `c_in`=0 gives 0x001E with `c_out`=0.
- R8: With the second-level skip enabled (`L2_SKIP`=1), each carry into an even-numbered group is identical to the single-level carry, and the outputs equal those of R1 and R2.
- R9: The group size parameter `GRP` may be any divisor of `WIDTH`. The outputs obey R1 and R2 for a size of 2 as well as for the default of 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum bits |
| c_out | output | 1 | Carry out of the top bit |

## Verification
Whenever the inputs settle, the assertions check the full arithmetic result and the carry out. They also check, for each group, that a fully propagating group hands its carry-in straight through, that any other group uses its rippled carry, and that the paired bypass agrees with the single-level carry. Only the bench's scenarios show some behaviours. These include the long carry path from bit 0 to the top, the all-propagate operand pairs with both carry-in values, and the generate-versus-propagate distinction in a bit with both inputs high. The bench also compares a group size of 2 and the paired-bypass variant against the same expected sums.

// File: rtl/skip_adder.sv
module skip_adder #(
  parameter int WIDTH   = 16,
  parameter int GRP     = 4,
  parameter bit L2_SKIP = 1'b0
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             c_out
);
  localparam int NG = WIDTH / GRP;

  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prp;

  assign gen = a_in & b_in;
  assign prp = a_in ^ b_in;

  if (WIDTH % GRP != 0) begin : g_bad_size
    $error("GRP must divide WIDTH");
  end

  for (genvar k = 0; k < NG; k++) begin : gb
    logic           cin_g;
    logic [GRP:0]   rip;
    logic           bypass;
    logic           cl1;
    logic           cout_g;

    if (k == 0) begin : g_first
      assign cin_g = c_in;
    end else begin : g_next
      assign cin_g = gb[k-1].cout_g;
    end

    assign bypass = &prp[k*GRP +: GRP];

    always_comb begin
      rip[0] = cin_g;
      for (int j = 0; j < GRP; j++)
        rip[j+1] = gen[k*GRP+j] | (prp[k*GRP+j] & rip[j]);
    end

    assign cl1 = bypass ? cin_g : rip[GRP];

    if (L2_SKIP && (k % 2 == 1)) begin : g_pair
      logic both;
      assign both   = bypass & gb[k-1].bypass;
      assign cout_g = both ? gb[k-1].cin_g : cl1;
      always_comb begin
        AST_L2_SAME: assert (cout_g == cl1); // R8
      end
    end else begin : g_single
      assign cout_g = cl1;
    end

    assign sum_out[k*GRP +: GRP] = prp[k*GRP +: GRP] ^ rip[GRP-1:0];

    always_comb begin
      if (bypass) begin
        AST_SKIP_PASS: assert (cout_g == cin_g); // R5
      end else begin
        AST_RIPPLE_USED: assert (cout_g == rip[GRP]); // R6
      end
    end
  end

  assign c_out = gb[NG-1].cout_g;

  always_comb begin
    AST_SUM_EXACT: assert (sum_out == WIDTH'(a_in + b_in + WIDTH'(c_in))); // R1
    AST_CARRY_EXACT: assert (c_out == (({1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in}) >> WIDTH)); // R2
  end
endmodule

// File: tb/sim_skip_adder.sv
`timescale 1ns/100ps
module sim_skip_adder;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         ci;
    logic [W:0]   exp;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic ci = 1'b0;
  logic [W-1:0] s0, s1, s2;
  logic co0, co1, co2;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  item_t q[$];

  always #2 clk = ~clk;

  skip_adder #(.WIDTH(W), .GRP(4), .L2_SKIP(1'b0)) u0 (.a_in(a), .b_in(b), .c_in(ci), .sum_out(s0), .c_out(co0));
  skip_adder #(.WIDTH(W), .GRP(4), .L2_SKIP(1'b1)) u1 (.a_in(a), .b_in(b), .c_in(ci), .sum_out(s1), .c_out(co1));
  skip_adder #(.WIDTH(W), .GRP(2), .L2_SKIP(1'b0)) u2 (.a_in(a), .b_in(b), .c_in(ci), .sum_out(s2), .c_out(co2));

  task automatic drive(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic tc, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    a = ta; b = tb; ci = tc;
    it.a = ta; it.b = tb; it.ci = tc;
    it.exp = {1'b0, ta} + {1'b0, tb} + {{W{1'b0}}, tc};
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cmp(input string who, input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: a/b/ci result actual=%h expected=%h", tag, who, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      cmp("u0", it.tag, {co0, s0}, it.exp);
      cmp("u1 R8", it.tag, {co1, s1}, it.exp);
      cmp("u2 R9", it.tag, {co2, s2}, it.exp);
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive('0, '0, 1'b0, "R1 reset-state zero");
    drive(16'h1234, 16'h4321, 1'b0, "R1 plain");
    drive(16'hFFFF, 16'h0000, 1'b1, "R2 carry out");
    drive(16'h8000, 16'h8000, 1'b0, "R2 top generate");
    drive(16'hA5C3, ~16'hA5C3, 1'b0, "R3 all propagate ci0");
    drive(16'hA5C3, ~16'hA5C3, 1'b1, "R3 all propagate ci1");
    drive(16'h0000, 16'hFFFF, 1'b1, "R3 zero/ones ci1");
    drive(16'h0001, 16'hFFFF, 1'b0, "R4 worst path");
    drive(16'h00F0, 16'h000F, 1'b1, "R5 skip groups 0-1");
    drive(16'h0F0F, 16'h00F1, 1'b0, "R6 ripple in group");
    drive(16'h000F, 16'h000F, 1'b0, "R7 generate not propagate");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R7 all generate");
    drive(16'h00FF, 16'hFF00, 1'b1, "R8 paired skip");
    drive(16'h3333, 16'hCCCC, 1'b1, "R9 size two propagate");
    for (int i = 0; i < 2000; i++)
      drive(W'($urandom), W'($urandom), 1'($urandom), "R1 R2 random");
    @(posedge clk);
    @(posedge clk);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule